// File: doc/BRIEF.md
# Step Sequencer With Post-Step Delay

This block executes a stream of 8-bit step commands, one at a time, taken from a queue port with a valid/ready handshake. A step can pulse one of several trigger outputs that feed a target peripheral. It can also wait on an external trigger input, either for a level or for a transition. A step can also switch the post-step delay on or off. With the delay on, every executed step is followed by a stall. The stall lasts the number of sequencer clocks held in a 16-bit limit input, so triggers leave the block no faster than the peripheral can accept them.

Command byte layout: bits [7:4] hold the opcode and bits [3:0] hold an argument. Opcode 0x0 is control: argument 0b0110 turns the delay on and 0b0010 turns it off. Opcode 0x1 pulses the output picked by the low argument bits. Opcodes 0x2 and 0x3 wait for the picked input to be high or low. Opcodes 0x4 and 0x5 wait for a rising or a falling transition on it. Every other code is a no-op step. All inputs are taken as synchronous to `clk`.

Top module: `step_seq`

## Requirements
- R1: After reset, busy is 0, cmd_ready is 1, all trigger outputs are 0 and the post-step delay is off. The first command after reset is therefore followed by no stall.
- R2: cmd_ready is 1 only while the sequencer waits for a command. busy rises on the clock edge after an accepted handshake and stays 1 through execution and any stall. It drops on the edge where the next fetch begins.
- R3: Command 0x1s drives trig_out[s] high for exactly one clock. That clock is the first execution cycle, which directly follows the handshake edge. No other output bit is high then.
- R4: Command 0x06 turns the delay on, and a stall follows that command itself. Command 0x02 turns it off, and no stall follows it, even when the delay was on before it.
- R5: With the delay on, each step is followed by exactly delay_limit stall clocks. A limit of 0 adds none and a limit of 1 adds one.
- R6: delay_limit is sampled on the edge where a command completes. A change made during a stall leaves that stall unchanged and takes effect for the next command.
- R7: Commands 0x2s and 0x3s complete on the first execution cycle in which trig_in[s] is high or low respectively. Until then they hold the sequencer busy.
- R8: Commands 0x4s and 0x5s take a reference level of trig_in[s] in their first execution cycle. They complete only on a later cycle that shows a rising or falling change from the previous cycle. A transition that happens during an earlier stall, during fetch, or before the command starts never completes them.
- R9: Any code other than the above, including control codes with other arguments, is a one-cycle no-op. It still gets the stall when the delay is on.
- R10: With the delay off, a non-waiting command keeps busy high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Queue holds a command |
| cmd_ready | output | 1 | Sequencer accepts a command this cycle |
| cmd_data | input | 8 | Command byte |
| delay_limit | input | LIM_W (16) | Stall length in clocks |
| trig_in | input | N_IN (4) | External trigger inputs |
| trig_out | output | N_OUT (4) | Trigger pulse outputs |
| busy | output | 1 | A command is executing or stalling |

## Verification
The assertions check the rules that hold on every cycle. Trigger pulses are one-hot and last a single clock. busy only rises after a handshake. A stall only happens with the delay on, and its counter stays below the captured limit. A disable step never stalls, and a satisfied level wait completes at once. The bench scenarios alone show the timing that depends on history. These are the exact stall lengths, limit sampling at command completion, and that a transition during a stall is lost for a later edge wait. They are checked against a behavioural model on every clock and by directed busy-length counts.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_STALL = 2'd2
  } seq_state_t;

  localparam logic [3:0] OP_CTRL  = 4'h0;
  localparam logic [3:0] OP_PULSE = 4'h1;
  localparam logic [3:0] OP_WHI   = 4'h2;
  localparam logic [3:0] OP_WLO   = 4'h3;
  localparam logic [3:0] OP_WRISE = 4'h4;
  localparam logic [3:0] OP_WFALL = 4'h5;

  localparam logic [3:0] ARG_DLY_ON  = 4'b0110;
  localparam logic [3:0] ARG_DLY_OFF = 4'b0010;
endpackage

// File: rtl/step_edge_watch.sv
module step_edge_watch #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            keep_armed,
  input  logic [N_IN-1:0] trig_in,
  output logic [N_IN-1:0] rise_vec,
  output logic [N_IN-1:0] fall_vec
);
  logic [N_IN-1:0] ref_q;
  logic            armed_q;

  // reference level follows the inputs; detection only counts once armed
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      ref_q   <= trig_in;
      armed_q <= keep_armed;
    end
  end

  always_comb begin
    rise_vec = armed_q ? (trig_in & ~ref_q) : '0;
    fall_vec = armed_q ? (~trig_in & ref_q) : '0;
  end

  // R8: a detection requires the detector to have been armed on the previous edge
  p_detect_needs_arm_r8: assert property (@(posedge clk) disable iff (rst)
    (|(rise_vec | fall_vec)) |-> $past(keep_armed));
endmodule

// File: rtl/step_stall_timer.sv
module step_stall_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit_in,
  output logic             expire
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;

  // cleared and reloaded on every execution cycle; the last load is the one at completion
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      lim_q <= limit_in;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = (({1'b0, cnt_q} + 1'b1) == {1'b0, lim_q});

  // R5: during a stall the count never reaches the captured limit
  p_cnt_below_lim_r5: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt_q < lim_q));
endmodule

// File: rtl/step_pulse_out.sv
module step_pulse_out #(
  parameter int N_OUT = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [SEL_W-1:0] sel,
  output logic [N_OUT-1:0] trig_out
);
  logic [N_OUT-1:0] pulse_q;
  logic [N_OUT-1:0] dec;

  always_comb begin
    for (int i = 0; i < N_OUT; i++) dec[i] = (sel == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= '0;
    else     pulse_q <= fire ? dec : '0;
  end

  assign trig_out = pulse_q;

  // R3: pulses are one-hot and last one clock
  p_pulse_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_out));
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    (|trig_out && !fire) |=> (trig_out == '0));
endmodule

// File: rtl/step_seq.sv
module step_seq
  import step_seq_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  input  logic [LIM_W-1:0] delay_limit,
  input  logic [N_IN-1:0]  trig_in,
  output logic [N_OUT-1:0] trig_out,
  output logic             busy
);
  localparam int IN_SEL_W  = (N_IN  > 1) ? $clog2(N_IN)  : 1;
  localparam int OUT_SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  seq_state_t      state_q, state_nx;
  logic [7:0]      cmd_q;
  logic            dly_en_q, en_after;
  logic            ready_q, busy_q;
  logic            done, go_stall, take;
  logic            stall_expire;
  logic [N_IN-1:0] rise_vec, fall_vec;
  logic [3:0]      op, arg;
  logic [IN_SEL_W-1:0] isel;

  assign op   = cmd_q[7:4];
  assign arg  = cmd_q[3:0];
  assign isel = cmd_q[IN_SEL_W-1:0];
  assign take = cmd_valid && ready_q;

  always_comb begin
    done     = 1'b1;
    en_after = dly_en_q;
    case (op)
      OP_CTRL: begin
        if (arg == ARG_DLY_ON)  en_after = 1'b1;
        if (arg == ARG_DLY_OFF) en_after = 1'b0;
      end
      OP_WHI:   done = trig_in[isel];
      OP_WLO:   done = !trig_in[isel];
      OP_WRISE: done = rise_vec[isel];
      OP_WFALL: done = fall_vec[isel];
      default:  done = 1'b1;
    endcase
  end

  assign go_stall = done && en_after && (delay_limit != '0);

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_FETCH: if (take) state_nx = ST_EXEC;
      ST_EXEC:  if (done) state_nx = go_stall ? ST_STALL : ST_FETCH;
      ST_STALL: if (stall_expire) state_nx = ST_FETCH;
      default:  state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH;
      cmd_q    <= '0;
      dly_en_q <= 1'b0;
      ready_q  <= 1'b1;
      busy_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      ready_q <= (state_nx == ST_FETCH);
      busy_q  <= (state_nx != ST_FETCH);
      if (take) cmd_q <= cmd_data;
      if (state_q == ST_EXEC) dly_en_q <= en_after;
    end
  end

  assign cmd_ready = ready_q;
  assign busy      = busy_q;

  step_edge_watch #(.N_IN(N_IN)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .keep_armed (state_q == ST_EXEC && !done),
    .trig_in    (trig_in),
    .rise_vec   (rise_vec),
    .fall_vec   (fall_vec)
  );

  step_stall_timer #(.LIM_W(LIM_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (state_q == ST_EXEC),
    .tick     (state_q == ST_STALL),
    .limit_in (delay_limit),
    .expire   (stall_expire)
  );

  step_pulse_out #(.N_OUT(N_OUT), .SEL_W(OUT_SEL_W)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .fire     (take && (cmd_data[7:4] == OP_PULSE)),
    .sel      (cmd_data[OUT_SEL_W-1:0]),
    .trig_out (trig_out)
  );

  // R2: busy only rises after an accepted handshake
  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(cmd_valid && cmd_ready));
  // R4: a stall only happens with the delay on
  p_stall_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STALL) |-> dly_en_q);
  // R4: a disable step returns straight to fetch
  p_off_no_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && op == OP_CTRL && arg == ARG_DLY_OFF) |=> cmd_ready);
  // R7: a satisfied high-level wait leaves execution on the next edge
  p_level_done_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC && op == OP_WHI && trig_in[isel]) |=> (state_q != ST_EXEC));
endmodule

// File: tb/tb_step_seq.sv
module tb_step_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_data = '0;
  logic [15:0] delay_limit = '0;
  logic [3:0]  trig_in = '0;
  logic [3:0]  trig_out;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // behavioural reference state
  int   m_phase = 0;   // 0 wait for command, 1 executing, 2 stalling
  int   m_cmd = 0, m_cnt = 0, m_lim = 0;
  bit   m_en = 0, m_first = 0;
  logic [3:0] m_ref = '0, m_trig = '0;

  step_seq dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .delay_limit(delay_limit), .trig_in(trig_in),
    .trig_out(trig_out), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_phase = 0; m_en = 0; m_trig = '0; m_first = 0;
    end else begin
      case (m_phase)
        0: begin
          m_trig = '0;
          if (cmd_valid) begin
            m_cmd = cmd_data; m_phase = 1; m_first = 1;
            if (cmd_data[7:4] == 4'h1) m_trig = 4'b1 << cmd_data[1:0];
          end
        end
        1: begin
          bit fin;
          int s;
          m_trig = '0;
          s = m_cmd & 3;
          case (m_cmd >> 4)
            2: fin = trig_in[s];
            3: fin = !trig_in[s];
            4: fin = !m_first && trig_in[s] && !m_ref[s];
            5: fin = !m_first && !trig_in[s] && m_ref[s];
            default: fin = 1;
          endcase
          if (m_cmd == 8'h06) m_en = 1;
          if (m_cmd == 8'h02) m_en = 0;
          m_ref = trig_in; m_first = 0;
          if (fin) begin
            if (m_en && delay_limit != 0) begin
              m_phase = 2; m_cnt = 0; m_lim = delay_limit;
            end else m_phase = 0;
          end
        end
        default: begin
          m_cnt++;
          if (m_cnt == m_lim) m_phase = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 busy", busy, m_phase != 0);
      check("R2 ready", cmd_ready, m_phase == 0);
      check("R3 trig_out", trig_out, m_trig);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // sends one command and returns the number of busy cycles it caused
  task automatic issue(input logic [7:0] c, output int n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_data = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 ready", cmd_ready, 1);
    check("R1 trig_out", trig_out, 0);
    rst = 1'b0;
    delay_limit = 16'd3;
    issue(8'h10, n); check("R1 delay off", n, 1);
    for (int k = 1; k < 4; k++) begin
      issue(8'h10 | 8'(k), n); check("R10 pulse length", n, 1);
    end
    issue(8'h9A, n); check("R9 no-op", n, 1);
    issue(8'h0F, n); check("R9 unknown control", n, 1);
    issue(8'h06, n); check("R4 enable stalls", n, 4);
    issue(8'h11, n); check("R5 limit 3", n, 4);
    issue(8'h9A, n); check("R9 no-op stall", n, 4);
    delay_limit = 16'd0;
    issue(8'h12, n); check("R5 limit 0", n, 1);
    delay_limit = 16'd1;
    issue(8'h12, n); check("R5 limit 1", n, 2);
    delay_limit = 16'd5;
    fork
      issue(8'h13, n);
      begin repeat (4) @(negedge clk); delay_limit = 16'd1; end
    join
    check("R6 limit held", n, 6);
    issue(8'h10, n); check("R6 new limit", n, 2);
    delay_limit = 16'd0;
    trig_in = 4'b0000;
    fork
      issue(8'h20, n);
      begin
        repeat (5) @(negedge clk);
        check("R7 high wait holds", busy, 1);
        trig_in[0] = 1'b1;
      end
    join
    fork
      issue(8'h30, n);
      begin
        repeat (5) @(negedge clk);
        check("R7 low wait holds", busy, 1);
        trig_in[0] = 1'b0;
      end
    join
    delay_limit = 16'd4;
    trig_in = 4'b0001;
    fork
      issue(8'h20, n);
      begin repeat (3) @(negedge clk); trig_in[1] = 1'b1; end
    join
    check("R8 stall length", n, 5);
    fork
      issue(8'h41, n);
      begin
        repeat (8) @(negedge clk);
        check("R8 stall edge lost", busy, 1);
        trig_in[1] = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 fall ignored by rise wait", busy, 1);
        trig_in[1] = 1'b1;
      end
    join
    fork
      issue(8'h51, n);
      begin repeat (4) @(negedge clk); trig_in[1] = 1'b0; end
    join
    issue(8'h02, n); check("R4 disable no stall", n, 1);
    issue(8'h11, n); check("R4 delay now off", n, 1);
    repeat (3) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule